// File: doc/BRIEF.md
# Drive Select Exchange and Media-Sense Register

This block holds one byte-wide configuration register for a floppy and tape drive subsystem. Two of its bits choose how the controller's internal drive-select and motor-enable lines reach the external drive pins. With them, software can swap drive 0 with drive 1, or drive 0 with drive 2, so that a different physical unit acts as the boot drive. When the subsystem runs with four-drive encoding, no swap is applied. Two more bits name the logical drive that holds a tape unit. Drive 0 stays reserved for the boot floppy, so it can never be named.

A read returns the stored configuration bits. It also returns a three-bit media field. In automatic media-sense mode, this field carries the identification code and a "no information" flag for the drive being accessed. Only drives 0 and 1 supply sense data. Every other drive reads as "no information". In compatible mode, the field always reads as "no information". A decoded media kind is also provided as an output for the rest of the controller.

Inside the block, the pin routing is held in a small state machine with three states:
- `ROUTE_STRAIGHT`: no exchange.
- `ROUTE_SWAP01`: drive 0 and drive 1 swapped.
- `ROUTE_SWAP02`: drive 0 and drive 2 swapped.

The next state is chosen at every clock edge. If four-drive encoding is high, the machine goes to `ROUTE_STRAIGHT`. Otherwise, the exchange code picks the state: 01 goes to `ROUTE_SWAP01`, 10 goes to `ROUTE_SWAP02`, and 00 or 11 go to `ROUTE_STRAIGHT`. When a write happens, the code is taken from the write data, so the state always follows the register in the same clock edge. Any state can move to any other state in one edge.

Top module: `drive_xchg_cfg`

## Requirements
- R1: After reset, all stored bits are 0. Register bits 4:0 read 0, `tape_sel` is 0 and the pins follow the internal signals unchanged.
- R2: On a clock edge with `reg_wr` high, `reg_wdata[3:0]` is stored. Bits 3:2 are the exchange code and bits 1:0 are the tape code. They read back in the same positions from the next cycle. Bit 4 always reads 0. Without `reg_wr`, the stored value does not change.
- R3: Exchange code 00 or 11 routes `sel_int[i]`/`mtr_int[i]` to `sel_pin[i]`/`mtr_pin[i]` for every drive.
- R4: Exchange code 01 swaps drives 0 and 1 on both select and motor pins. Drives 2 and 3 stay straight.
- R5: Exchange code 10 swaps drives 0 and 2 symmetrically on both select and motor pins. Drives 1 and 3 stay straight.
- R6: While `four_drive` is high, every pin is routed straight, whatever the exchange code. The routing follows `four_drive` from the clock edge after it changes.
- R7: `tape_drive` equals the tape code. `tape_sel` is one-hot on bit n for codes 1, 2 and 3. It is all zero for code 0, and `tape_sel[0]` is never set.
- R8: With `auto_sense` high and `acc_drive` equal to 0 or 1, read bit 5 equals that drive's `no_info` input. Bits 7:6 carry that drive's ID when bit 5 is 0, and read 00 otherwise.
- R9: With `auto_sense` high and `acc_drive` equal to 2 or 3, bit 5 reads 1 and bits 7:6 read 00.
- R10: With `auto_sense` low (compatible mode), bit 5 reads 1 and bits 7:6 read 00. This holds with `four_drive` high or low.
- R11: `media_kind` is 0 when bit 5 is 1. Otherwise it is 1 for ID 00 (5.25-inch), 2 for ID 01 (2.88 MB), 3 for ID 10 (1.44 MB) and 4 for ID 11 (720 KB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sel_int | input | 4 | Internal drive-select signals |
| mtr_int | input | 4 | Internal motor-enable signals |
| sel_pin | output | 4 | Drive-select pins after exchange |
| mtr_pin | output | 4 | Motor-enable pins after exchange |
| acc_drive | input | 2 | Drive currently accessed |
| media_id0 | input | 2 | Media ID sensed on drive 0 |
| media_id1 | input | 2 | Media ID sensed on drive 1 |
| no_info | input | 2 | Per-drive "no media information" flags for drives 0 and 1 |
| four_drive | input | 1 | Four-drive encoding mode |
| auto_sense | input | 1 | Automatic media-sense mode |
| tape_drive | output | 2 | Logical tape drive number (0 = none) |
| tape_sel | output | 4 | One-hot tape drive marker |
| media_kind | output | 3 | Decoded media kind of the accessed drive |

## Verification
The hardest case to reach is the one where `four_drive` changes on its own while a swap code stays stored. The pins must go back to straight routing one edge later, and then return to the swap when the mode bit falls again. Nothing is written in between. The stimulus table pairs each exchange code with distinct one-hot and mixed patterns on the select and motor lines, so a swap that is wrong in only one direction shows up. The four-drive vectors are run with swap codes already loaded. A directed test then holds a code and toggles only `four_drive`.

// File: rtl/dsx_pkg.sv
package dsx_pkg;

    typedef enum logic [1:0] {
        ROUTE_STRAIGHT = 2'd0,
        ROUTE_SWAP01   = 2'd1,
        ROUTE_SWAP02   = 2'd2
    } route_e;

    typedef enum logic [2:0] {
        MEDIA_NONE  = 3'd0,
        MEDIA_525   = 3'd1,
        MEDIA_288M  = 3'd2,
        MEDIA_144M  = 3'd3,
        MEDIA_720K  = 3'd4
    } media_e;

    localparam int XCHG_LSB = 2;
    localparam int TAPE_LSB = 0;
    localparam int NOINFO_BIT = 5;
    localparam int ID_LSB = 6;

    localparam logic [1:0] XCODE_NONE = 2'b00;
    localparam logic [1:0] XCODE_01   = 2'b01;
    localparam logic [1:0] XCODE_02   = 2'b10;

endpackage

// File: rtl/dsx_cfg_reg.sv
module dsx_cfg_reg #(
    parameter int CODE_W = 2,
    parameter int N_DRV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] xchg_in,
    input  logic [CODE_W-1:0] tape_in,
    output logic [CODE_W-1:0] xchg_q,
    output logic [CODE_W-1:0] tape_q,
    output logic [N_DRV-1:0]  tape_sel
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xchg_q <= '0;
            tape_q <= '0;
        end else if (wr) begin
            xchg_q <= xchg_in;
            tape_q <= tape_in;
        end
    end

    // drive 0 is the boot floppy and is never marked as tape
    assign tape_sel[0] = 1'b0;
    for (genvar d = 1; d < N_DRV; d++) begin : g_tape
        assign tape_sel[d] = (tape_q == CODE_W'(d));
    end

endmodule

// File: rtl/dsx_route_fsm.sv
module dsx_route_fsm
    import dsx_pkg::*;
#(
    parameter int N_DRV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       code_next,
    input  logic             four_drive,
    input  logic [N_DRV-1:0] sel_int,
    input  logic [N_DRV-1:0] mtr_int,
    output logic [N_DRV-1:0] sel_pin,
    output logic [N_DRV-1:0] mtr_pin
);

    localparam int IDX_W = (N_DRV > 1) ? $clog2(N_DRV) : 1;

    route_e state_q, state_d;

    always_comb begin
        state_d = ROUTE_STRAIGHT;
        if (!four_drive) begin
            unique case (code_next)
                XCODE_01: state_d = ROUTE_SWAP01;
                XCODE_02: state_d = ROUTE_SWAP02;
                default:  state_d = ROUTE_STRAIGHT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ROUTE_STRAIGHT;
        else        state_q <= state_d;
    end

    function automatic logic [IDX_W-1:0] src_of(input route_e st, input int pin);
        logic [IDX_W-1:0] s;
        s = IDX_W'(pin);
        unique case (st)
            ROUTE_SWAP01: begin
                if (pin == 0) s = IDX_W'(1);
                else if (pin == 1) s = IDX_W'(0);
            end
            ROUTE_SWAP02: begin
                if (pin == 0) s = IDX_W'(2);
                else if (pin == 2) s = IDX_W'(0);
            end
            default: s = IDX_W'(pin);
        endcase
        return s;
    endfunction

    for (genvar p = 0; p < N_DRV; p++) begin : g_pin
        always_comb begin
            sel_pin[p] = sel_int[src_of(state_q, p)];
            mtr_pin[p] = mtr_int[src_of(state_q, p)];
        end
    end

endmodule

// File: rtl/dsx_media_rd.sv
module dsx_media_rd
    import dsx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              auto_sense,
    input  logic [1:0]        acc_drive,
    input  logic [1:0]        media_id0,
    input  logic [1:0]        media_id1,
    input  logic [1:0]        no_info,
    input  logic [1:0]        xchg_q,
    input  logic [1:0]        tape_q,
    output logic [DATA_W-1:0] rdata,
    output logic [2:0]        media_kind
);

    logic       flag;
    logic [1:0] id;

    always_comb begin
        flag = 1'b1;
        id   = 2'b00;
        if (auto_sense) begin
            unique case (acc_drive)
                2'd0: begin flag = no_info[0]; id = media_id0; end
                2'd1: begin flag = no_info[1]; id = media_id1; end
                default: begin flag = 1'b1; id = 2'b00; end
            endcase
        end
        if (flag) id = 2'b00;
    end

    always_comb begin
        rdata = '0;
        rdata[ID_LSB +: 2]   = id;
        rdata[NOINFO_BIT]    = flag;
        rdata[XCHG_LSB +: 2] = xchg_q;
        rdata[TAPE_LSB +: 2] = tape_q;
    end

    always_comb begin
        if (flag) media_kind = MEDIA_NONE;
        else      media_kind = 3'(id) + 3'd1;
    end

endmodule

// File: rtl/drive_xchg_cfg.sv
module drive_xchg_cfg
    import dsx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_DRV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_DRV-1:0]  sel_int,
    input  logic [N_DRV-1:0]  mtr_int,
    output logic [N_DRV-1:0]  sel_pin,
    output logic [N_DRV-1:0]  mtr_pin,
    input  logic [1:0]        acc_drive,
    input  logic [1:0]        media_id0,
    input  logic [1:0]        media_id1,
    input  logic [1:0]        no_info,
    input  logic              four_drive,
    input  logic              auto_sense,
    output logic [1:0]        tape_drive,
    output logic [N_DRV-1:0]  tape_sel,
    output logic [2:0]        media_kind
);

    logic [1:0] xchg_q, tape_q, code_next;
    logic       unused_hi;

    assign unused_hi = ^reg_wdata[DATA_W-1:XCHG_LSB+2];

    dsx_cfg_reg #(.CODE_W(2), .N_DRV(N_DRV)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .xchg_in  (reg_wdata[XCHG_LSB +: 2]),
        .tape_in  (reg_wdata[TAPE_LSB +: 2]),
        .xchg_q   (xchg_q),
        .tape_q   (tape_q),
        .tape_sel (tape_sel)
    );

    assign code_next  = reg_wr ? reg_wdata[XCHG_LSB +: 2] : xchg_q;
    assign tape_drive = tape_q;

    dsx_route_fsm #(.N_DRV(N_DRV)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_next  (code_next),
        .four_drive (four_drive),
        .sel_int    (sel_int),
        .mtr_int    (mtr_int),
        .sel_pin    (sel_pin),
        .mtr_pin    (mtr_pin)
    );

    dsx_media_rd #(.DATA_W(DATA_W)) u_media (
        .auto_sense (auto_sense),
        .acc_drive  (acc_drive),
        .media_id0  (media_id0),
        .media_id1  (media_id1),
        .no_info    (no_info),
        .xchg_q     (xchg_q),
        .tape_q     (tape_q),
        .rdata      (reg_rdata),
        .media_kind (media_kind)
    );

endmodule

// File: rtl/drive_xchg_cfg_chk.sv
module drive_xchg_cfg_chk #(
    parameter int DATA_W = 8,
    parameter int N_DRV  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_DRV-1:0]  sel_int,
    input logic [N_DRV-1:0]  mtr_int,
    input logic [N_DRV-1:0]  sel_pin,
    input logic [N_DRV-1:0]  mtr_pin,
    input logic [1:0]        acc_drive,
    input logic              four_drive,
    input logic              auto_sense,
    input logic [N_DRV-1:0]  tape_sel,
    input logic [2:0]        media_kind
);

    AST_WR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr) |-> reg_rdata[3:0] == $past(reg_wdata[3:0])); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] == 1'b0); // R2

    AST_SWAP01_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(four_drive) && $past(reg_wr) && $past(reg_wdata[3:2]) == 2'b01)
        |-> (sel_pin[0] == sel_int[1] && sel_pin[1] == sel_int[0]
             && mtr_pin[0] == mtr_int[1] && mtr_pin[1] == mtr_int[0])); // R4

    AST_FOUR_DRV_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(four_drive) |-> (sel_pin == sel_int && mtr_pin == mtr_int)); // R6

    AST_TAPE_NOT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tape_sel) && !tape_sel[0]); // R7

    AST_OTHER_DRV_NOINFO: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_sense && acc_drive[1]) |-> (reg_rdata[7:5] == 3'b001)); // R9

    AST_COMPAT_NOINFO: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_sense |-> (reg_rdata[7:5] == 3'b001)); // R10

    AST_KIND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] == (media_kind == 3'd0)); // R11

endmodule

bind drive_xchg_cfg drive_xchg_cfg_chk #(.DATA_W(DATA_W), .N_DRV(N_DRV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sel_int    (sel_int),
    .mtr_int    (mtr_int),
    .sel_pin    (sel_pin),
    .mtr_pin    (mtr_pin),
    .acc_drive  (acc_drive),
    .four_drive (four_drive),
    .auto_sense (auto_sense),
    .tape_sel   (tape_sel),
    .media_kind (media_kind)
);

// File: tb/test_drive_xchg_cfg.sv
`timescale 1ns/1ps
module test_drive_xchg_cfg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] sel_int = '0, mtr_int = '0, sel_pin, mtr_pin, tape_sel;
    logic [1:0] acc_drive = '0, media_id0 = '0, media_id1 = '0, no_info = '0, tape_drive;
    logic       four_drive = 1'b0, auto_sense = 1'b0;
    logic [2:0] media_kind;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    drive_xchg_cfg i_drive_xchg_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sel_int(sel_int), .mtr_int(mtr_int),
        .sel_pin(sel_pin), .mtr_pin(mtr_pin), .acc_drive(acc_drive),
        .media_id0(media_id0), .media_id1(media_id1), .no_info(no_info),
        .four_drive(four_drive), .auto_sense(auto_sense),
        .tape_drive(tape_drive), .tape_sel(tape_sel), .media_kind(media_kind)
    );

    // {four_drive, code[1:0], sel_int, mtr_int, exp sel_pin, exp mtr_pin}
    localparam logic [18:0] ROUTE_VEC [10] = '{
        {1'b0, 2'b00, 4'b0001, 4'b0011, 4'b0001, 4'b0011}, // R3
        {1'b0, 2'b01, 4'b0001, 4'b0010, 4'b0010, 4'b0001}, // R4
        {1'b0, 2'b01, 4'b1010, 4'b0100, 4'b1001, 4'b0100}, // R4
        {1'b0, 2'b10, 4'b0001, 4'b0100, 4'b0100, 4'b0001}, // R5
        {1'b0, 2'b10, 4'b0010, 4'b1000, 4'b0010, 4'b1000}, // R5
        {1'b0, 2'b10, 4'b0100, 4'b0011, 4'b0001, 4'b0110}, // R5
        {1'b0, 2'b11, 4'b0010, 4'b0001, 4'b0010, 4'b0001}, // R3
        {1'b0, 2'b11, 4'b0101, 4'b1001, 4'b0101, 4'b1001}, // R3
        {1'b1, 2'b01, 4'b0001, 4'b0010, 4'b0001, 4'b0010}, // R6
        {1'b1, 2'b10, 4'b0100, 4'b0001, 4'b0100, 4'b0001}  // R6
    };

    // {auto, four, acc[1:0], no_info[1:0], id0, id1, exp rdata[7:5], exp kind}
    localparam logic [15:0] MEDIA_VEC [11] = '{
        {1'b1, 1'b0, 2'd0, 2'b00, 2'b00, 2'b11, 3'b000, 3'd1}, // R8 R11
        {1'b1, 1'b0, 2'd0, 2'b00, 2'b01, 2'b11, 3'b010, 3'd2}, // R8 R11
        {1'b1, 1'b0, 2'd1, 2'b00, 2'b00, 2'b10, 3'b100, 3'd3}, // R8 R11
        {1'b1, 1'b0, 2'd1, 2'b00, 2'b00, 2'b11, 3'b110, 3'd4}, // R8 R11
        {1'b1, 1'b0, 2'd0, 2'b01, 2'b11, 2'b00, 3'b001, 3'd0}, // R8
        {1'b1, 1'b0, 2'd1, 2'b10, 2'b00, 2'b01, 3'b001, 3'd0}, // R8
        {1'b1, 1'b0, 2'd2, 2'b00, 2'b10, 2'b10, 3'b001, 3'd0}, // R9
        {1'b1, 1'b0, 2'd3, 2'b00, 2'b10, 2'b10, 3'b001, 3'd0}, // R9
        {1'b0, 1'b1, 2'd0, 2'b00, 2'b10, 2'b10, 3'b001, 3'd0}, // R10
        {1'b0, 1'b0, 2'd1, 2'b00, 2'b10, 2'b10, 3'b001, 3'd0}, // R10
        {1'b1, 1'b1, 2'd0, 2'b00, 2'b10, 2'b01, 3'b100, 3'd3}  // R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        sel_int = 4'b0110;
        mtr_int = 4'b1001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, compatible mode reads 0x20
        chk("R1 rdata", 32'(reg_rdata), 32'h20);
        chk("R1 sel", 32'(sel_pin), 32'(sel_int));
        chk("R1 mtr", 32'(mtr_pin), 32'(mtr_int));
        chk("R1 tape", 32'(tape_sel), 32'h0);

        for (int i = 0; i < 10; i++) begin
            logic [18:0] v;
            string tag;
            v = ROUTE_VEC[i];
            tag = v[18] ? "R6" : (v[17:16] == 2'b01) ? "R4" :
                  (v[17:16] == 2'b10) ? "R5" : "R3";
            @(negedge clk);
            four_drive = v[18];
            sel_int = v[15:12];
            mtr_int = v[11:8];
            write_reg({4'h0, v[17:16], 2'b00});
            chk({tag, " sel"}, 32'(sel_pin), 32'(v[7:4]));
            chk({tag, " mtr"}, 32'(mtr_pin), 32'(v[3:0]));
        end

        // R6 four_drive toggled alone with swap code 01 held
        four_drive = 1'b0;
        write_reg(8'h04);
        sel_int = 4'b0001; mtr_int = 4'b0001;
        @(negedge clk);
        chk("R6 pre swap", 32'(sel_pin), 32'h2);
        four_drive = 1'b1;
        @(negedge clk);
        chk("R6 suppressed", 32'(sel_pin), 32'h1);
        chk("R6 suppressed mtr", 32'(mtr_pin), 32'h1);
        four_drive = 1'b0;
        @(negedge clk);
        chk("R6 restored", 32'(mtr_pin), 32'h2);

        // R2 readback and reserved bit
        write_reg(8'hFF);
        chk("R2 readback", 32'(reg_rdata[4:0]), 32'h0F);
        @(negedge clk);
        reg_wdata = 8'h00;
        @(negedge clk);
        chk("R2 no write", 32'(reg_rdata[4:0]), 32'h0F);

        // R7 tape assignment
        for (int t = 0; t < 4; t++) begin
            write_reg(8'(t));
            chk("R7 tape_drive", 32'(tape_drive), 32'(t));
            chk("R7 tape_sel", 32'(tape_sel), (t == 0) ? 32'h0 : 32'(1 << t));
        end

        for (int i = 0; i < 11; i++) begin
            logic [15:0] m;
            m = MEDIA_VEC[i];
            @(negedge clk);
            auto_sense = m[15];
            four_drive = m[14];
            acc_drive = m[13:12];
            no_info = m[11:10];
            media_id0 = m[9:8];
            media_id1 = m[7:6];
            @(negedge clk);
            chk(m[15] ? (m[13] ? "R9 media" : "R8 media") : "R10 media",
                32'(reg_rdata[7:5]), 32'(m[5:3]));
            chk("R11 kind", 32'(media_kind), 32'(m[2:0]));
        end

        // R1 reset again clears storage
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rereset", 32'(reg_rdata[4:0]), 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule